// File: doc/BRIEF.md
# Flash Status and Write-Guard Controller

This block holds the device state that a serial flash reports in its status byte, and it uses that state to decide whether array operations may start. A command decoder hands it one decoded command at a time over a valid/ready channel. The block keeps three pieces of state: a write-enable latch, a busy timer that runs for a parameterised number of clock cycles after a read, write or erase is granted, and a pass/fail flag for the most recent write or erase.

For each read, write or erase it accepts, the block sends the array sequencer a one-cycle decision on the next cycle. The decision is either a grant carrying the operation, or an ignore carrying a reason. A status request returns an 8-bit word on a second valid/ready channel and may be made at any time, including while a timed cycle is still running.

Back-pressure works as follows. The command channel accepts a command on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` is low while a status word is waiting to be taken. The status channel holds `stat_valid_o` and `stat_data_o` steady until `stat_ready_i` is high on a clock edge. The grant and ignore outputs are plain one-cycle pulses with no back-pressure.

Top module: `flash_status_guard`

## Requirements
- R1: After reset the device is ready and writing is disabled. The pass flag reads as successful and no grant, ignore or status word is pending, so a status request returns 8'h41 (density parameter = 1).
- R2: The status word has busy on bit 7, the pass flag on bit 6, the write-enable latch on bit 5 and the density parameter on bit 0 (1 = larger part). Bits 4 to 1 read as 0.
- R3: A status request (op code 0) is accepted whether or not the device is busy. The word captures the state at the accepting edge and appears with `stat_valid_o` on the next cycle.
- R4: While `stat_valid_o` is high and `stat_ready_i` is low, the word and `stat_valid_o` stay unchanged and `cmd_ready_o` is low, so no command is taken.
- R5: Op code 4 sets the write-enable latch and op code 5 clears it. No other command changes the latch.
- R6: A write (op code 2) while the latch is clear produces `ignore_o` with `ignore_why_o` = 1 one cycle after acceptance, and starts no busy cycle.
- R7: A read, write or erase accepted while busy produces `ignore_o` with `ignore_why_o` = 0. The running busy count is not restarted or extended.
- R8: A granted read (op 1), write (op 2) or erase (op 3) raises `grant_valid_o` for one cycle after acceptance, with `grant_op_o` equal to the op code. `busy_o` is then high for exactly T_READ, T_WRITE or T_ERASE cycles respectively.
- R9: At the end of a write or erase, the pass flag takes the value of `op_pass_i` as sampled in the last busy cycle. A status request accepted on that same edge still reports the old flag. A read never changes the flag.
- R10: An erase is granted when idle whatever the state of the write-enable latch.
- R11: Op codes 6 and 7 are accepted and have no effect on any output or on the status word.
- R12: Reset during a busy cycle ends it at once and restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command can be taken |
| cmd_op_i | input | 3 | Op code: 0 status, 1 read, 2 write, 3 erase, 4 enable, 5 disable |
| op_pass_i | input | 1 | Result of the write/erase from the array, sampled in the last busy cycle |
| stat_valid_o | output | 1 | Status word present |
| stat_ready_i | input | 1 | Status word taken |
| stat_data_o | output | 8 | Status word |
| grant_valid_o | output | 1 | Array operation granted (pulse) |
| grant_op_o | output | 2 | Granted operation: 1 read, 2 write, 3 erase |
| ignore_o | output | 1 | Array operation ignored (pulse) |
| ignore_why_o | output | 1 | 0 = device busy, 1 = writing disabled |
| busy_o | output | 1 | Timed cycle in progress |

## Verification
The hardest case to reach from the ports is the edge where a write's busy cycle ends. On that edge the pass flag updates from `op_pass_i` while a status request is accepted in the same cycle. The stimulus table places a write and then a status request after exactly T_WRITE-1 idle cycles, so the request lands on the final busy edge. The bench holds the new result on `op_pass_i` during that request and expects the old flag, followed by the new flag one request later. A second corner comes from a rejected write issued in the middle of a read. A write granted three cycles later shows that the first count was not restarted.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [2:0] {
    OP_STATUS = 3'd0,
    OP_READ   = 3'd1,
    OP_WRITE  = 3'd2,
    OP_ERASE  = 3'd3,
    OP_WREN   = 3'd4,
    OP_WRDI   = 3'd5
  } fg_op_e;

  localparam int unsigned ST_BUSY_BIT = 7;
  localparam int unsigned ST_PASS_BIT = 6;
  localparam int unsigned ST_WEL_BIT  = 5;
  localparam int unsigned ST_DENS_BIT = 0;
  localparam int unsigned ST_W        = 8;

  localparam logic WHY_BUSY    = 1'b0;
  localparam logic WHY_PROTECT = 1'b1;

  function automatic logic fg_is_array(input logic [2:0] op);
    return (op == 3'(OP_READ)) || (op == 3'(OP_WRITE)) || (op == 3'(OP_ERASE));
  endfunction

endpackage

// File: rtl/fsg_wel_latch.sv
module fsg_wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wel_o <= 1'b0;
    else if (set_i) wel_o <= 1'b1;
    else if (clr_i) wel_o <= 1'b0;
  end

  // R5
  wel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_o) |-> $past(set_i));

  // R5
  wel_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wel_o) |-> $past(clr_i));

endmodule

// File: rtl/fsg_busy_timer.sv
module fsg_busy_timer #(
  parameter int unsigned T_READ  = 4,
  parameter int unsigned T_WRITE = 6,
  parameter int unsigned T_ERASE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] start_op_i,
  output logic       busy_o,
  output logic       done_wr_o
);

  localparam int unsigned T_RW  = (T_READ > T_WRITE) ? T_READ : T_WRITE;
  localparam int unsigned T_MAX = (T_RW > T_ERASE) ? T_RW : T_ERASE;
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             wr_q;

  always_comb begin
    case (start_op_i)
      2'd1:    load_val = CNT_W'(T_READ);
      2'd2:    load_val = CNT_W'(T_WRITE);
      default: load_val = CNT_W'(T_ERASE);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wr_q  <= 1'b0;
    end else if (start_i) begin
      cnt_q <= load_val;
      wr_q  <= (start_op_i != 2'd1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o    = (cnt_q != '0);
  assign done_wr_o = (cnt_q == CNT_W'(1)) && wr_q;

  // R7
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);

  // R8
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);

endmodule

// File: rtl/fsg_status_fmt.sv
module fsg_status_fmt
  import flash_guard_pkg::*;
#(
  parameter bit DENSITY_HI = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          wel_i,
  input  logic          done_wr_i,
  input  logic          pass_i,
  input  logic          req_i,
  input  logic          stat_ready_i,
  output logic          stat_valid_o,
  output logic [ST_W-1:0] stat_data_o
);

  logic            pass_q;
  logic [ST_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pass_q <= 1'b1;
    else if (done_wr_i) pass_q <= pass_i;
  end

  always_comb begin
    word              = '0;
    word[ST_BUSY_BIT] = busy_i;
    word[ST_PASS_BIT] = pass_q;
    word[ST_WEL_BIT]  = wel_i;
    word[ST_DENS_BIT] = DENSITY_HI;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid_o <= 1'b0;
      stat_data_o  <= '0;
    end else if (req_i) begin
      stat_valid_o <= 1'b1;
      stat_data_o  <= word;
    end else if (stat_ready_i) begin
      stat_valid_o <= 1'b0;
    end
  end

  // R4
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid_o && !stat_ready_i) |=> (stat_valid_o && $stable(stat_data_o)));

  // R9
  pass_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pass_q) |-> $past(busy_i));

endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
  import flash_guard_pkg::*;
#(
  parameter int unsigned T_READ     = 4,
  parameter int unsigned T_WRITE    = 6,
  parameter int unsigned T_ERASE    = 8,
  parameter bit          DENSITY_HI = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid_i,
  output logic       cmd_ready_o,
  input  logic [2:0] cmd_op_i,
  input  logic       op_pass_i,
  output logic       stat_valid_o,
  input  logic       stat_ready_i,
  output logic [7:0] stat_data_o,
  output logic       grant_valid_o,
  output logic [1:0] grant_op_o,
  output logic       ignore_o,
  output logic       ignore_why_o,
  output logic       busy_o
);

  logic acc, is_arr, protect, grant_d, reject_d, wel, done_wr;

  assign acc     = cmd_valid_i && cmd_ready_o;
  assign is_arr  = acc && fg_is_array(cmd_op_i);
  assign protect = (cmd_op_i == 3'(OP_WRITE)) && !wel;
  assign grant_d  = is_arr && !busy_o && !protect;
  assign reject_d = is_arr && !grant_d;
  assign cmd_ready_o = !stat_valid_o;

  fsg_wel_latch u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (acc && (cmd_op_i == 3'(OP_WREN))),
    .clr_i (acc && (cmd_op_i == 3'(OP_WRDI))),
    .wel_o (wel)
  );

  fsg_busy_timer #(
    .T_READ  (T_READ),
    .T_WRITE (T_WRITE),
    .T_ERASE (T_ERASE)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (grant_d),
    .start_op_i (cmd_op_i[1:0]),
    .busy_o     (busy_o),
    .done_wr_o  (done_wr)
  );

  fsg_status_fmt #(
    .DENSITY_HI (DENSITY_HI)
  ) u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy_o),
    .wel_i        (wel),
    .done_wr_i    (done_wr),
    .pass_i       (op_pass_i),
    .req_i        (acc && (cmd_op_i == 3'(OP_STATUS))),
    .stat_ready_i (stat_ready_i),
    .stat_valid_o (stat_valid_o),
    .stat_data_o  (stat_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid_o <= 1'b0;
      grant_op_o    <= 2'd0;
      ignore_o      <= 1'b0;
      ignore_why_o  <= WHY_BUSY;
    end else begin
      grant_valid_o <= grant_d;
      grant_op_o    <= grant_d ? cmd_op_i[1:0] : 2'd0;
      ignore_o      <= reject_d;
      ignore_why_o  <= (reject_d && !busy_o) ? WHY_PROTECT : WHY_BUSY;
    end
  end

  // R8
  grant_ignore_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_valid_o && ignore_o));

  // R6
  write_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && grant_op_o == 2'd2) |-> $past(wel));

  // R7
  no_grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && fg_is_array(cmd_op_i) && busy_o) |=> (ignore_o && !grant_valid_o));

  // R4
  no_accept_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid_o && !stat_ready_i) |-> !cmd_ready_o);

endmodule

// File: tb/flash_status_guard_tb.sv
module flash_status_guard_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic       cmd_ready_o;
  logic [2:0] cmd_op_i = 3'd0;
  logic       op_pass_i = 1'b1;
  logic       stat_valid_o;
  logic       stat_ready_i = 1'b1;
  logic [7:0] stat_data_o;
  logic       grant_valid_o;
  logic [1:0] grant_op_o;
  logic       ignore_o;
  logic       ignore_why_o;
  logic       busy_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  flash_status_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_op_i(cmd_op_i), .op_pass_i(op_pass_i), .stat_valid_o(stat_valid_o),
    .stat_ready_i(stat_ready_i), .stat_data_o(stat_data_o), .grant_valid_o(grant_valid_o),
    .grant_op_o(grant_op_o), .ignore_o(ignore_o), .ignore_why_o(ignore_why_o), .busy_o(busy_o)
  );

  // fields: op[17:15] pass[14] kind[13:12] stat[11:4] gap[3:0]
  // kind: 0 nothing, 1 grant, 2 ignore busy, 3 ignore protect
  localparam int NV = 18;
  localparam logic [17:0] VEC [NV] = '{
    {3'd0, 1'b1, 2'd0, 8'h41, 4'd1},  // R1 R2 reset status
    {3'd2, 1'b1, 2'd3, 8'h00, 4'd0},  // R6 write without enable
    {3'd4, 1'b1, 2'd0, 8'h00, 4'd0},  // R5 enable
    {3'd0, 1'b1, 2'd0, 8'h61, 4'd1},  // R5 status shows enable
    {3'd1, 1'b1, 2'd1, 8'h00, 4'd0},  // R8 read granted
    {3'd0, 1'b1, 2'd0, 8'hE1, 4'd1},  // R3 status while busy
    {3'd2, 1'b1, 2'd2, 8'h00, 4'd3},  // R7 write rejected while busy
    {3'd2, 1'b0, 2'd1, 8'h00, 4'd5},  // R7 not restarted: write granted
    {3'd0, 1'b0, 2'd0, 8'hE1, 4'd1},  // R9 status on final busy edge, old flag
    {3'd0, 1'b0, 2'd0, 8'h21, 4'd1},  // R9 new flag
    {3'd6, 1'b0, 2'd0, 8'h00, 4'd0},  // R11 unused code
    {3'd0, 1'b0, 2'd0, 8'h21, 4'd1},  // R11 unchanged
    {3'd5, 1'b0, 2'd0, 8'h00, 4'd0},  // R5 disable
    {3'd3, 1'b1, 2'd1, 8'h00, 4'd0},  // R10 erase without enable
    {3'd1, 1'b1, 2'd2, 8'h00, 4'd8},  // R7 read while erasing
    {3'd0, 1'b1, 2'd0, 8'h41, 4'd1},  // R9 erase pass
    {3'd2, 1'b1, 2'd3, 8'h00, 4'd0},  // R6 write protected again
    {3'd0, 1'b1, 2'd0, 8'h41, 4'd1}   // R6 no busy, no flag change
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic issue(input logic [2:0] op, input logic pass);
    while (!cmd_ready_o) @(negedge clk);
    cmd_valid_i = 1'b1;
    cmd_op_i    = op;
    op_pass_i   = pass;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state at the ports
    chk(!busy_o && !stat_valid_o && !grant_valid_o && !ignore_o && cmd_ready_o, "R1",
        {busy_o, stat_valid_o, grant_valid_o, ignore_o, cmd_ready_o}, 5'b00001);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic [1:0] kind;
      op   = VEC[i][17:15];
      kind = VEC[i][13:12];
      issue(op, VEC[i][14]);
      chk(grant_valid_o == (kind == 2'd1), "R8", grant_valid_o, kind == 2'd1);
      chk(ignore_o == kind[1], "R6/R7", ignore_o, kind[1]);
      if (kind == 2'd1) chk(grant_op_o == op[1:0], "R8", grant_op_o, op[1:0]);
      if (kind[1]) chk(ignore_why_o == kind[0], "R7", ignore_why_o, kind[0]);
      if (op == 3'd0) begin
        chk(stat_valid_o, "R3", stat_valid_o, 1);
        chk(stat_data_o == VEC[i][11:4], "R2", stat_data_o, VEC[i][11:4]);
      end
      repeat (VEC[i][3:0]) @(negedge clk);
    end

    // R4 status back-pressure, a queued enable waits
    stat_ready_i = 1'b0;
    issue(3'd0, 1'b1);
    cmd_valid_i = 1'b1;
    cmd_op_i    = 3'd4;
    for (int k = 0; k < 3; k++) begin
      chk(stat_valid_o && !cmd_ready_o && stat_data_o == 8'h41, "R4",
          {stat_valid_o, cmd_ready_o, stat_data_o}, {2'b10, 8'h41});
      @(negedge clk);
    end
    stat_ready_i = 1'b1;
    @(negedge clk);
    chk(!stat_valid_o && cmd_ready_o, "R4", {stat_valid_o, cmd_ready_o}, 2'b01);
    @(negedge clk);
    cmd_valid_i = 1'b0;
    @(negedge clk);
    issue(3'd0, 1'b1);
    chk(stat_data_o == 8'h61, "R5", stat_data_o, 8'h61);
    @(negedge clk);

    // R8 exact busy lengths
    begin
      int n;
      issue(3'd1, 1'b1);
      n = 0;
      while (busy_o && n < 50) begin n++; @(negedge clk); end
      chk(n == 4, "R8", n, 4);
      issue(3'd2, 1'b1);
      n = 0;
      while (busy_o && n < 50) begin n++; @(negedge clk); end
      chk(n == 6, "R8", n, 6);
    end

    // R12 reset during erase
    issue(3'd3, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy_o, "R12", busy_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(3'd0, 1'b1);
    chk(stat_data_o == 8'h41, "R12", stat_data_o, 8'h41);
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule